// File: doc/BRIEF.md
# SMBus Clock-High Timeout Start Sequencer

This block is the bus-side front end of an I2C master with a guard on how long SCL may stay high. When software issues a one-cycle start command while the master is idle, the block waits one SCL-low period with both lines released, then pulls SDA low to form a START condition. It waits another SCL-low period and then pulls SCL low. After that it produces a fixed number of SCL pulses with SDA held low; shifting real data bits is left to logic outside this block. Finally it releases both lines and returns to idle. All periods are counted in system clock ticks and are set on input ports.

A down-counter watches SCL-high time for the whole transaction. It is loaded with the programmed limit in the same cycle that the start command is accepted, not on a bus edge. It is reloaded on every SCL rise and freezes while SCL is low. If the counter runs out, the master drops the transaction, releases both lines and sets a sticky flag. The counter is armed before the START condition exists. So with a long SCL-low period, the start sequence alone can hit the limit on a healthy bus. The enable input lets the check be switched off at slow bus rates. With a 200 MHz system clock, the usual 50 us SMBus ceiling is a limit of 10000 ticks.

Top module: `smbus_start_guard`

## Requirements
- R1: While reset is asserted, and after it, with no start command, the block drives scl_o = 1, sda_o = 1, busy = 0 and timeout_flag = 0.
- R2: If start_cmd is high at a clock edge while the block is idle, busy rises at that edge. Both lines stay high for low_ticks cycles. Then sda_o is 0 with scl_o at 1 for low_ticks cycles. Then scl_o goes to 0.
- R3: After the START condition, the block gives NBITS pulses, each low_ticks cycles with scl_o at 0 followed by high_ticks cycles with scl_o at 1. sda_o stays 0 for all of them. Then the block drives both lines to 1 and drops busy.
- R4: The high-time counter is loaded with limit_ticks when a start is accepted. It loses one per cycle in which scl_o is 1 while busy. It holds while scl_o is 0, and it is loaded again with limit_ticks on each rise of scl_o.
- R5: When enabled and scl_o has been 1 for limit_ticks counted cycles, the block goes idle at the next edge with both lines at 1. So the start sequence times out exactly when 2*low_ticks >= limit_ticks, and a pulse times out exactly when high_ticks >= limit_ticks.
- R6: timeout_flag becomes 1 at the edge where the block goes idle on a timeout. It stays 1 through later transactions until to_clear is high at an edge. A timeout at the same edge takes precedence over the clear.
- R7: While to_enable is 0, no timeout occurs and every transaction runs to completion.
- R8: start_cmd has no effect while busy, and this includes the edge at which a timeout returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_cmd | input | 1 | One-cycle request to begin a transaction |
| to_enable | input | 1 | 1 enables the SCL-high timeout check |
| to_clear | input | 1 | One-cycle clear of timeout_flag |
| low_ticks | input | CNT_W | SCL-low period in clock cycles (at least 1) |
| high_ticks | input | CNT_W | SCL-high period in clock cycles (at least 1) |
| limit_ticks | input | CNT_W | Maximum SCL-high time in clock cycles (at least 1) |
| scl_o | output | 1 | SCL drive, 1 = released high |
| sda_o | output | 1 | SDA drive, 1 = released high |
| busy | output | 1 | Transaction in progress |
| timeout_flag | output | 1 | Sticky SCL-high timeout indication |

## Verification
Random transactions draw the low period, high period and limit from small ranges, and randomly turn the check on or off. This covers three outcomes: a start-sequence timeout, a first-pulse timeout and a clean completion. Each one gives a different cycle-exact waveform. Directed cases scale the slow-clock situation to 30/20/50 ticks and compare it with the check turned off. They also place the limit on both sides of 2*low_ticks, and pick a pulse that passes only because the counter reloads on each SCL rise. Further cases issue start commands while busy and at the timeout edge, and compare the flag when it is cleared against when it is left sticky.

// File: rtl/ssg_pkg.sv
`timescale 1ns/1ps
package ssg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_HOLD,
    ST_LOW,
    ST_HIGH
  } seq_st_e;
endpackage

// File: rtl/ssg_rst_sync.sv
`timescale 1ns/1ps
module ssg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/ssg_seq.sv
`timescale 1ns/1ps
module ssg_seq
  import ssg_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int NBITS = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_cmd,
  input  logic             abort,
  input  logic [CNT_W-1:0] low_ticks,
  input  logic [CNT_W-1:0] high_ticks,
  output seq_st_e          state_q,
  output logic             launch,
  output logic             scl_rise
);
  localparam int BIT_W = $clog2(NBITS + 1);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(NBITS - 1);

  seq_st_e          state_d;
  logic [CNT_W-1:0] ph_q, ph_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic             ph_done;

  assign ph_done  = (ph_q == '0);
  assign launch   = (state_q == ST_IDLE) && start_cmd;
  assign scl_rise = (state_q == ST_LOW) && ph_done;

  always_comb begin
    state_d = state_q;
    bit_d   = bit_q;
    ph_d    = ph_done ? ph_q : ph_q - ONE;
    case (state_q)
      ST_IDLE: if (launch) begin
        state_d = ST_PRE;
        ph_d    = low_ticks - ONE;
      end
      ST_PRE: if (ph_done) begin
        state_d = ST_HOLD;
        ph_d    = low_ticks - ONE;
      end
      ST_HOLD: if (ph_done) begin
        state_d = ST_LOW;
        ph_d    = low_ticks - ONE;
        bit_d   = '0;
      end
      ST_LOW: if (ph_done) begin
        state_d = ST_HIGH;
        ph_d    = high_ticks - ONE;
      end
      ST_HIGH: if (ph_done) begin
        if (bit_q == LAST_BIT) begin
          state_d = ST_IDLE;
        end else begin
          state_d = ST_LOW;
          ph_d    = low_ticks - ONE;
          bit_d   = bit_q + BIT_W'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (abort) state_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ph_q    <= '0;
      bit_q   <= '0;
    end else begin
      state_q <= state_d;
      ph_q    <= ph_d;
      bit_q   <= bit_d;
    end
  end

  // R2: the released phase lasts until its tick count is used up
  a_r2_pre_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PRE && ph_q != '0 && !abort) |=> (state_q == ST_PRE));
  // R8: a start request during a low phase leaves the phase alone
  a_r8_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOW && start_cmd && ph_q != '0) |=> (state_q == ST_LOW));
  // R3: pulse index stays within the configured count
  a_r3_bit_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_q <= LAST_BIT));
endmodule

// File: rtl/ssg_tmo.sv
`timescale 1ns/1ps
module ssg_tmo
  import ssg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             clear,
  input  logic [CNT_W-1:0] limit,
  input  seq_st_e          state,
  input  logic             launch,
  input  logic             scl_rise,
  output logic             abort,
  output logic             flag_q
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] tmo_q, tmo_d;
  logic             tmo_en, flag_d, scl_hi;

  assign scl_hi = (state == ST_PRE) || (state == ST_HOLD) || (state == ST_HIGH);
  assign abort  = enable && scl_hi && (tmo_q <= ONE);

  always_comb begin
    tmo_en = 1'b0;
    tmo_d  = tmo_q;
    if (launch || scl_rise) begin
      tmo_en = 1'b1;
      tmo_d  = limit;
    end else if (scl_hi && tmo_q != '0) begin
      tmo_en = 1'b1;
      tmo_d  = tmo_q - ONE;
    end
    flag_d = abort ? 1'b1 : (clear ? 1'b0 : flag_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmo_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (tmo_en) tmo_q <= tmo_d;
      flag_q <= flag_d;
    end
  end

  // R4: counter reloads to the limit on arm and on each SCL rise
  a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (launch || scl_rise) |=> (tmo_q == $past(limit)));
  // R4: counter frozen while SCL is held low
  a_r4_frozen_low: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOW && !scl_rise) |=> $stable(tmo_q));
  // R6: the flag only rises because of an abort
  a_r6_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(abort));
endmodule

// File: rtl/smbus_start_guard.sv
`timescale 1ns/1ps
module smbus_start_guard
  import ssg_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int NBITS = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_cmd,
  input  logic             to_enable,
  input  logic             to_clear,
  input  logic [CNT_W-1:0] low_ticks,
  input  logic [CNT_W-1:0] high_ticks,
  input  logic [CNT_W-1:0] limit_ticks,
  output logic             scl_o,
  output logic             sda_o,
  output logic             busy,
  output logic             timeout_flag
);
  logic    rst_n_s;
  seq_st_e state;
  logic    launch, scl_rise, abort;

  ssg_rst_sync #(.STAGES(2)) i_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  ssg_seq #(.CNT_W(CNT_W), .NBITS(NBITS)) i_seq (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .start_cmd  (start_cmd),
    .abort      (abort),
    .low_ticks  (low_ticks),
    .high_ticks (high_ticks),
    .state_q    (state),
    .launch     (launch),
    .scl_rise   (scl_rise)
  );

  ssg_tmo #(.CNT_W(CNT_W)) i_tmo (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .enable   (to_enable),
    .clear    (to_clear),
    .limit    (limit_ticks),
    .state    (state),
    .launch   (launch),
    .scl_rise (scl_rise),
    .abort    (abort),
    .flag_q   (timeout_flag)
  );

  assign busy  = (state != ST_IDLE);
  assign scl_o = (state != ST_LOW);
  assign sda_o = (state == ST_IDLE) || (state == ST_PRE);

  // R5: an abort leaves the bus released and the master idle
  a_r5_abort_idle: assert property (@(posedge clk) disable iff (!rst_n_s)
    abort |=> (!busy && scl_o && sda_o));
  // R7: with the check off a running transaction never raises the flag
  a_r7_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!to_enable && busy) |=> !$rose(timeout_flag));
  // R2: SCL is never pulled low before SDA
  a_r2_sda_first: assert property (@(posedge clk) disable iff (!rst_n_s)
    $fell(scl_o) |-> !sda_o);
endmodule

// File: tb/test_smbus_start_guard.sv
`timescale 1ns/1ps
module test_smbus_start_guard;
  localparam int CNT_W = 16;
  localparam int NB    = 9;

  logic             clk = 1'b0;
  logic             rst_n, start_cmd, to_enable, to_clear;
  logic [CNT_W-1:0] low_ticks, high_ticks, limit_ticks;
  logic             scl_o, sda_o, busy, timeout_flag;

  int n_cmp = 0;
  int n_bad = 0;
  bit sticky = 0;
  bit done = 0;

  smbus_start_guard #(.CNT_W(CNT_W), .NBITS(NB)) i_smbus_start_guard (
    .clk(clk), .rst_n(rst_n), .start_cmd(start_cmd), .to_enable(to_enable),
    .to_clear(to_clear), .low_ticks(low_ticks), .high_ticks(high_ticks),
    .limit_ticks(limit_ticks), .scl_o(scl_o), .sda_o(sda_o), .busy(busy),
    .timeout_flag(timeout_flag)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s t=%0t act={scl,sda,busy,flag}=%b exp=%b", tag, $time, act, exp);
    end
  endtask

  // cycle index at which the block is idle again; timed tells whether by timeout
  function automatic int calc_end(int lo, int hi, int lim, bit en, output bit timed);
    timed = 0;
    if (en && 2 * lo >= lim) begin
      timed = 1; return lim;
    end
    if (en && hi >= lim) begin
      timed = 1; return 3 * lo + lim;
    end
    return 2 * lo + NB * (lo + hi);
  endfunction

  function automatic logic [1:0] exp_lines(int k, int lo, int hi, int e);
    int j;
    if (k >= e)      return 2'b11;
    if (k < lo)      return 2'b11;
    if (k < 2 * lo)  return 2'b10;
    j = (k - 2 * lo) % (lo + hi);
    return (j < lo) ? 2'b00 : 2'b10;
  endfunction

  task automatic run_txn(input int lo, input int hi, input int lim, input bit en,
                         input bit do_clear, input bit busy_start, input bit edge_start,
                         input string tag);
    bit timed;
    int e;
    logic [1:0] ln;
    e = calc_end(lo, hi, lim, en, timed);
    @(negedge clk);
    low_ticks = CNT_W'(lo); high_ticks = CNT_W'(hi); limit_ticks = CNT_W'(lim);
    to_enable = en;
    if (do_clear) begin
      to_clear = 1'b1;
      @(negedge clk);
      to_clear = 1'b0;
      sticky = 0;
      check("R6", {scl_o, sda_o, busy, timeout_flag}, 4'b1100);
    end
    start_cmd = 1'b1;
    @(negedge clk);
    start_cmd = 1'b0;
    for (int k = 0; k <= e + 2; k++) begin
      ln = exp_lines(k, lo, hi, e);
      check((k < 2 * lo) ? "R2" : ((edge_start && k >= e) ? "R8" : tag),
            {scl_o, sda_o, busy, 1'b0}, {ln, (k < e), 1'b0});
      check("R6", {3'b000, timeout_flag}, {3'b000, sticky | (timed && k >= e)});
      if (busy_start && k == lo + 1 && k < e) start_cmd = 1'b1;
      if (edge_start && k == e - 1) start_cmd = 1'b1;
      @(negedge clk);
      start_cmd = 1'b0;
    end
    if (timed) sticky = 1;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240);
    rst_n = 1'b0; start_cmd = 1'b0; to_enable = 1'b0; to_clear = 1'b0;
    low_ticks = 16'd1; high_ticks = 16'd1; limit_ticks = 16'd1;
    #12;
    check("R1", {scl_o, sda_o, busy, timeout_flag}, 4'b1100);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", {scl_o, sda_o, busy, timeout_flag}, 4'b1100);

    // R5: slow-clock case scaled to ticks, start sequence alone exceeds the limit
    run_txn(30, 20, 50, 1, 0, 0, 0, "R5");
    // R7: same timing with the check disabled completes
    run_txn(30, 20, 50, 0, 0, 0, 0, "R7");
    // R6: cleared flag, then boundary 2*low == limit times out
    run_txn(5, 3, 10, 1, 1, 0, 0, "R5");
    // boundary 2*low == limit-1 passes
    run_txn(5, 3, 11, 1, 1, 0, 0, "R3");
    // R4: passes only because each SCL rise reloads the counter
    run_txn(2, 9, 10, 1, 0, 0, 0, "R4");
    // R5: high period equal to limit times out in first pulse
    run_txn(2, 6, 6, 1, 0, 0, 0, "R5");
    // R8: start while busy and at the timeout edge
    run_txn(3, 4, 12, 1, 1, 1, 1, "R8");
    run_txn(3, 4, 5, 1, 0, 1, 1, "R8");
    // R3: minimum periods
    run_txn(1, 1, 40, 1, 1, 0, 0, "R3");

    for (int i = 0; i < 150; i++) begin
      int lo, hi, lim;
      bit en, clr;
      lo  = 1 + int'($urandom_range(0, 7));
      hi  = 1 + int'($urandom_range(0, 7));
      lim = 1 + int'($urandom_range(0, 39));
      en  = bit'($urandom_range(0, 1));
      clr = bit'($urandom_range(0, 1));
      run_txn(lo, hi, lim, en, clr, bit'($urandom_range(0, 1)), 1'b0, "R3");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule